// File: doc/BRIEF.md
# Linear Burst Bus Master

This engine moves a block of FIFO data between a local FIFO and memory over a 486-style local bus, using linear burst cycles where the target agrees to them. It is started with a byte address, a byte count and a direction. It then walks the word addresses, issuing an address strobe to open each burst and data-only phases to continue it. Address bits below the word boundary never reach the bus. They become active-low byte enables on the first and last words. Bus arbitration is outside the block: the engine behaves as if it already owns the bus, and it keeps the bus until the count is used up.

A burst is limited to four times a 3-bit length code. When that limit is reached and data remains, the engine reopens with a fresh strobe at the next word address. A target joins a burst by answering with the burst-ready strobe. An answer on the plain ready strobe ends the burst after that word. Bursting has one enable for memory reads and another for memory writes, and it applies only to FIFO transfers.

The FIFO side follows valid/ready rules. The source (memory writes) must present its head word with `src_valid` and keep it stable until `src_ready` pops it. The sink (memory reads) must keep `snk_ready` high once raised until `snk_valid` pushes a word. `snk_valid` pulses only in the cycle a ready strobe completes a data phase, and the sink cannot stall a push. Two lookahead flags report whether the FIFO can also serve the word after the current one. This lets the engine close a burst before it runs the FIFO dry.

Top module: `lburst_master`

## Requirements
- R1: A transfer is issued as bursts only when `fifo_xfer` is high, the length code is nonzero, and the burst enable for the direction is set (`wr_burst_en` when `dir_wr`=1, `rd_burst_en` when `dir_wr`=0). Otherwise every word is a separate cycle with `blast_n` low.
- R2: If the target completes a data phase with `rdy_n` low, the burst ends, even when `brdy_n` is also low. The next word opens with a new address strobe.
- R3: Each burst opens with `ads_n` low for exactly one cycle, followed by its first data phase. Further words of the same burst carry no strobe.
- R4: A burst holds at most 4×`burst_code` words. When the limit is reached and words remain, a new strobe is issued at the next word address.
- R5: `addr` is the word address of the current data phase. It is held through wait states and rises by one after every completed word, including across a burst continuation.
- R6: `be_n` bit i is low when byte lane i lies inside the transfer: on the first word only lanes at or above start address bits [1:0], on the last word only lanes at or below the end byte's bits [1:0], all lanes on middle words.
- R7: `blast_n` goes low in the final data phase of a burst, whether the burst ends at the length limit or at the last word. Once low, it stays low until a ready strobe completes that phase.
- R8: A FIFO word is popped (`src_ready`) or pushed (`snk_valid`) only in a cycle where `brdy_n` or `rdy_n` is low during a data phase. `dout` carries the source head word, and `snk_data` carries `din`. Each word moves exactly once.
- R9: If the FIFO cannot serve the following word (`src_has2` low on writes, `snk_room2` low on reads), the current phase is marked last with `blast_n`.
- R10: After reset, and after any start with `xfer_bytes`=0, the bus is idle: `ads_n` and `blast_n` high, `busy` low, and no FIFO handshake. `done` pulses one cycle after the final word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| start_addr | input | 32 | Starting byte address |
| xfer_bytes | input | 16 | Byte count; 0 is ignored |
| dir_wr | input | 1 | 1: FIFO to memory, 0: memory to FIFO |
| fifo_xfer | input | 1 | Transfer is FIFO data (bursting allowed) |
| rd_burst_en | input | 1 | Allow bursts on memory reads |
| wr_burst_en | input | 1 | Allow bursts on memory writes |
| burst_code | input | 3 | Burst length code, limit = 4×code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at completion |
| ads_n | output | 1 | Address strobe, active low |
| addr | output | 30 | Word address (byte address bits 31:2) |
| be_n | output | 4 | Byte enables, active low |
| wr | output | 1 | 1 = write cycle |
| blast_n | output | 1 | Last phase of burst, active low |
| dout | output | 32 | Write data |
| dout_en | output | 1 | Write data is driven |
| din | input | 32 | Read data |
| brdy_n | input | 1 | Burst ready from target |
| rdy_n | input | 1 | Normal ready from target |
| src_valid | input | 1 | Source FIFO head is valid |
| src_has2 | input | 1 | Source holds a word behind the head |
| src_data | input | 32 | Source FIFO head word |
| src_ready | output | 1 | Pop the source head |
| snk_ready | input | 1 | Sink can take a word |
| snk_room2 | input | 1 | Sink has room for two words |
| snk_valid | output | 1 | Push `snk_data` into the sink |
| snk_data | output | 32 | Word pushed into the sink |

## Verification
Several rules are checked on every clock: the strobe lasts one cycle, the address is held after a strobe and steps by one across a burst continuation, `blast_n` stays low once raised until a ready arrives, FIFO handshakes occur only alongside a ready strobe, and no burst passes its length limit. Other behaviour needs whole transfers and is shown only by the bench's scenarios. That includes the choice between burst and single cycles (direction enables, zero code, non-FIFO traffic, a target answering plain ready), byte-enable patterns on unaligned starts and ends, the early close when the FIFO lookahead flag is low, and the data carried on each word.

// File: rtl/lbm_pkg.sv
`timescale 1ns/1ps
package lbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } lbm_state_e;
endpackage

// File: rtl/lbm_be_decode.sv
`timescale 1ns/1ps
// Byte-lane enable decode for the first / last word of a transfer.
module lbm_be_decode #(
  parameter int LANES = 4,
  parameter int OFS   = 2
) (
  input  logic [OFS-1:0]   first_lo,
  input  logic [OFS-1:0]   last_lo,
  input  logic             is_first,
  input  logic             is_last,
  output logic [LANES-1:0] be_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lo_ok, hi_ok;
    assign lo_ok   = !is_first || (OFS'(i) >= first_lo);
    assign hi_ok   = !is_last  || (OFS'(i) <= last_lo);
    assign be_n[i] = !(lo_ok && hi_ok);
  end
endmodule

// File: rtl/lbm_beat_ctr.sv
`timescale 1ns/1ps
// Counts the position of the current word inside a burst (1-based).
module lbm_beat_ctr #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              at_limit
);
  localparam int BW = CODE_W + 2;
  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= BW'(1);
    else if (clear)  cnt <= BW'(1);
    else if (step)   cnt <= cnt + BW'(1);
  end

  assign at_limit = (cnt == {code, 2'b00});
endmodule

// File: rtl/lburst_master.sv
`timescale 1ns/1ps
module lburst_master
  import lbm_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LEN_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [LEN_W-1:0]  xfer_bytes,
  input  logic              dir_wr,
  input  logic              fifo_xfer,
  input  logic              rd_burst_en,
  input  logic              wr_burst_en,
  input  logic [CODE_W-1:0] burst_code,
  output logic              busy,
  output logic              done,
  output logic              ads_n,
  output logic [AW-$clog2(DW/8)-1:0] addr,
  output logic [DW/8-1:0]   be_n,
  output logic              wr,
  output logic              blast_n,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  input  logic [DW-1:0]     din,
  input  logic              brdy_n,
  input  logic              rdy_n,
  input  logic              src_valid,
  input  logic              src_has2,
  input  logic [DW-1:0]     src_data,
  output logic              src_ready,
  input  logic              snk_ready,
  input  logic              snk_room2,
  output logic              snk_valid,
  output logic [DW-1:0]     snk_data
);
  localparam int LANES = DW / 8;
  localparam int OFS   = $clog2(LANES);
  localparam int WA    = AW - OFS;

  lbm_state_e        st;
  logic [WA-1:0]     word_q;
  logic [LEN_W-1:0]  rem_q;
  logic [OFS-1:0]    first_lo_q, last_lo_q;
  logic              first_q, dir_q, burst_ok_q, blast_hold, done_q;
  logic [CODE_W-1:0] code_q;

  // start decode
  logic [AW-1:0] end_byte;
  logic [WA-1:0] word_span;
  logic          dir_en, go;
  assign end_byte  = start_addr + AW'(xfer_bytes) - AW'(1);
  assign word_span = end_byte[AW-1:OFS] - start_addr[AW-1:OFS] + WA'(1);
  assign dir_en    = dir_wr ? wr_burst_en : rd_burst_en;
  assign go        = (st == ST_IDLE) && start && (xfer_bytes != '0);

  // data-phase decode
  logic in_data, rdy_any, is_last, next_ok, at_limit, blast_cond, ends, avail;
  assign in_data    = (st == ST_DATA);
  assign rdy_any    = !brdy_n || !rdy_n;
  assign is_last    = (rem_q == LEN_W'(1));
  assign next_ok    = dir_q ? src_has2 : snk_room2;
  assign blast_cond = !burst_ok_q || at_limit || is_last || !next_ok;
  assign blast_n    = !(in_data && (blast_cond || blast_hold));
  assign ends       = !rdy_n || !blast_n;
  assign avail      = dir_q ? src_valid : snk_ready;

  lbm_beat_ctr #(.CODE_W(CODE_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (st == ST_ADDR),
    .step     (in_data && rdy_any && !ends),
    .code     (code_q),
    .at_limit (at_limit)
  );

  lbm_be_decode #(.LANES(LANES), .OFS(OFS)) u_be (
    .first_lo (first_lo_q),
    .last_lo  (last_lo_q),
    .is_first (first_q),
    .is_last  (is_last),
    .be_n     (be_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      word_q     <= '0;
      rem_q      <= '0;
      first_lo_q <= '0;
      last_lo_q  <= '0;
      first_q    <= 1'b0;
      dir_q      <= 1'b0;
      burst_ok_q <= 1'b0;
      code_q     <= '0;
      blast_hold <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_data && !rdy_any && blast_cond) blast_hold <= 1'b1;
      else if (!in_data || rdy_any)          blast_hold <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          word_q     <= start_addr[AW-1:OFS];
          rem_q      <= LEN_W'(word_span);
          first_lo_q <= start_addr[OFS-1:0];
          last_lo_q  <= end_byte[OFS-1:0];
          first_q    <= 1'b1;
          dir_q      <= dir_wr;
          code_q     <= burst_code;
          burst_ok_q <= fifo_xfer && (burst_code != '0) && dir_en;
          st         <= ST_WAIT;
        end
        ST_WAIT: if (avail) st <= ST_ADDR;
        ST_ADDR: st <= ST_DATA;
        ST_DATA: if (rdy_any) begin
          word_q  <= word_q + WA'(1);
          rem_q   <= rem_q - LEN_W'(1);
          first_q <= 1'b0;
          if (is_last) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else if (ends) begin
            st <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign ads_n     = (st != ST_ADDR);
  assign addr      = word_q;
  assign wr        = dir_q;
  assign dout      = src_data;
  assign dout_en   = in_data && dir_q;
  assign src_ready = in_data && dir_q && rdy_any;
  assign snk_valid = in_data && !dir_q && rdy_any;
  assign snk_data  = din;
endmodule

// File: rtl/lburst_master_chk.sv
`timescale 1ns/1ps
module lburst_master_chk #(
  parameter int WA     = 30,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ads_n,
  input logic [WA-1:0]     addr,
  input logic              blast_n,
  input logic              brdy_n,
  input logic              rdy_n,
  input logic              src_ready,
  input logic              snk_valid,
  input logic [CODE_W-1:0] code_q
);
  localparam int CW = CODE_W + 3;
  logic          hs;
  logic [CW-1:0] beats;
  assign hs = src_ready || snk_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beats <= '0;
    else if (!ads_n) beats <= '0;
    else if (hs)     beats <= beats + CW'(1);
  end

  a_r3_ads_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> $stable(addr));

  a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !brdy_n && rdy_n && blast_n) |=> (ads_n && addr == WA'($past(addr) + 1'b1)));

  a_r7_blast_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && brdy_n && rdy_n) |=> !blast_n);

  a_r8_pop_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!brdy_n || !rdy_n));

  a_r8_push_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |-> (!brdy_n || !rdy_n));

  a_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && snk_valid));

  a_r4_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && code_q != '0) |-> (beats < CW'({code_q, 2'b00})));
endmodule

bind lburst_master lburst_master_chk #(.WA(WA), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ads_n     (ads_n),
  .addr      (addr),
  .blast_n   (blast_n),
  .brdy_n    (brdy_n),
  .rdy_n     (rdy_n),
  .src_ready (src_ready),
  .snk_valid (snk_valid),
  .code_q    (code_q)
);

// File: tb/lburst_master_bench.sv
`timescale 1ns/1ps
module lburst_master_bench;
  typedef struct {
    logic [29:0] a;
    logic [3:0]  be_n;
    bit          nw;
    bit          bl;
    logic [31:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] xfer_bytes = '0;
  logic        dir_wr = 1'b0, fifo_xfer = 1'b0, rd_burst_en = 1'b0, wr_burst_en = 1'b0;
  logic [2:0]  burst_code = '0;
  logic        busy, done, ads_n, wr, blast_n, dout_en;
  logic [29:0] addr;
  logic [3:0]  be_n;
  logic [31:0] dout, snk_data;
  logic [31:0] din = '0;
  logic        brdy_n = 1'b1, rdy_n = 1'b1;
  logic        src_valid = 1'b0, src_has2 = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_ready;
  logic        snk_ready = 1'b1, snk_room2 = 1'b1;
  logic        snk_valid;

  always #2.5 clk = ~clk;

  lburst_master u_lburst_master (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .xfer_bytes(xfer_bytes), .dir_wr(dir_wr), .fifo_xfer(fifo_xfer),
    .rd_burst_en(rd_burst_en), .wr_burst_en(wr_burst_en), .burst_code(burst_code),
    .busy(busy), .done(done), .ads_n(ads_n), .addr(addr), .be_n(be_n), .wr(wr),
    .blast_n(blast_n), .dout(dout), .dout_en(dout_en), .din(din),
    .brdy_n(brdy_n), .rdy_n(rdy_n), .src_valid(src_valid), .src_has2(src_has2),
    .src_data(src_data), .src_ready(src_ready), .snk_ready(snk_ready),
    .snk_room2(snk_room2), .snk_valid(snk_valid), .snk_data(snk_data)
  );

  int nrun = 0, nfail = 0, nrcv = 0, nads = 0;
  item_t       exp_q[$];
  logic [31:0] sq[$];

  function automatic logic [31:0] memf(input logic [29:0] w);
    return {w[13:0], 2'b10, ~w[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic refresh_src();
    src_valid = (sq.size() > 0);
    src_has2  = (sq.size() > 1);
    src_data  = (sq.size() > 0) ? sq[0] : 32'h0;
  endtask

  // target model state
  bit acc_mode = 1'b1;
  int wst = 0, wcnt = 0;
  bit rdy_drv = 0, last_cont = 0, prev_addr = 0, prev_data = 0, cur_new = 0, chk_pend = 0;
  bit comp, dnow;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      rdy_drv = 0; last_cont = 0; prev_addr = 0; prev_data = 0; chk_pend = 0; wcnt = 0;
    end else begin
      if (!ads_n) nads++;
      comp = rdy_drv;
      if (rdy_drv) begin
        rdy_drv = 0; brdy_n = 1'b1; rdy_n = 1'b1;
        if (dir_wr && sq.size() > 0) void'(sq.pop_front());
        refresh_src();
      end
      dnow = prev_addr || (comp && last_cont) || (prev_data && !comp);
      if (prev_addr) cur_new = 1'b1;
      else if (comp && last_cont) cur_new = 1'b0;
      prev_addr = !ads_n;
      prev_data = dnow;
      if (dnow) begin
        if (wcnt < wst) wcnt++;
        else begin
          wcnt = 0;
          rdy_drv = 1;
          if (acc_mode) brdy_n = 1'b0; else rdy_n = 1'b0;
          din = memf(addr);
          chk_pend = 1;
        end
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (chk_pend) begin
      item_t e;
      chk_pend = 0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected data phase", 32'(addr), 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(addr == e.a, "R5", "word address", 32'(addr), 32'(e.a));
        chk(be_n == e.be_n, "R6", "byte enables", 32'(be_n), 32'(e.be_n));
        chk(cur_new == e.nw, "R3 R4 R2", "strobe before phase", 32'(cur_new), 32'(e.nw));
        chk(blast_n == !e.bl, "R7 R1 R9", "burst last", 32'(blast_n), 32'(!e.bl));
        if (dir_wr) begin
          chk(src_ready && dout_en && wr, "R8", "pop with ready", 32'(src_ready), 32'h1);
          chk(dout == e.d, "R8", "write data", dout, e.d);
        end else begin
          chk(snk_valid && !wr, "R8", "push with ready", 32'(snk_valid), 32'h1);
          chk(snk_data == e.d, "R8", "read data", snk_data, e.d);
          nrcv++;
        end
      end
      last_cont = acc_mode && blast_n;
    end
  end

  task automatic run_xfer(input logic [31:0] sa, input int bytes, input bit dw,
                          input bit fx, input bit ren, input bit wen, input int code,
                          input bit acc, input int ws, input bit room, input string tag);
    logic [29:0] fw, lw, w;
    logic [31:0] ea, a;
    logic [3:0]  m;
    int n, lim, k, cyc;
    bit ok, prev_end, got;
    item_t it;
    ea = sa + bytes - 1;
    fw = sa[31:2];
    lw = ea[31:2];
    n  = int'(lw - fw) + 1;
    ok = fx && (code != 0) && (dw ? wen : ren);
    lim = code * 4;
    k = 1;
    prev_end = 1'b1;
    for (int i = 0; i < n; i++) begin
      w = fw + 30'(i);
      m = '0;
      for (int b = 0; b < bytes; b++) begin
        a = sa + b;
        if (a[31:2] == w) m[a[1:0]] = 1'b1;
      end
      it.a    = w;
      it.be_n = ~m;
      it.nw   = prev_end;
      it.bl   = !ok || (k == lim) || (i == n - 1) || (!dw && !room);
      it.d    = dw ? (32'hC0DE_0000 + 32'(i) + sa) : memf(w);
      prev_end = it.bl || !acc;
      k = prev_end ? 1 : k + 1;
      exp_q.push_back(it);
      if (dw) sq.push_back(32'hC0DE_0000 + 32'(i) + sa);
    end
    nrcv = 0;
    @(posedge clk); #1;
    refresh_src();
    acc_mode = acc; wst = ws; snk_room2 = room;
    start_addr = sa; xfer_bytes = 16'(bytes); dir_wr = dw; fifo_xfer = fx;
    rd_burst_en = ren; wr_burst_en = wen; burst_code = 3'(code);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    got = 0;
    cyc = 0;
    while (!got && cyc < 2000) begin
      @(negedge clk);
      if (done) got = 1;
      cyc++;
    end
    chk(got, tag, "done pulse", 32'(got), 32'h1);
    @(negedge clk);
    chk(exp_q.size() == 0, tag, "words left unissued", 32'(exp_q.size()), 32'h0);
    if (dw) chk(sq.size() == 0, "R8", "source words left", 32'(sq.size()), 32'h0);
    else    chk(nrcv == n, "R8", "sink word count", 32'(nrcv), 32'(n));
    chk(!busy && ads_n && blast_n, "R10", "idle after done", 32'(busy), 32'h0);
    exp_q.delete();
    sq.delete();
    refresh_src();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nrun++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ads_n && blast_n && !busy && !done, "R10", "reset bus idle", {28'h0, ads_n, blast_n, busy, done}, 32'hC);
    chk(!src_ready && !snk_valid, "R10", "reset no handshake", {30'h0, src_ready, snk_valid}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // zero-length start is ignored (R10)
    nads = 0;
    xfer_bytes = '0; start_addr = 32'h40; start = 1'b1; dir_wr = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!busy && nads == 0 && !done, "R10", "zero count ignored", 32'(nads), 32'h0);

    // sa, bytes, dir, fifo, ren, wen, code, accept, waits, room
    run_xfer(32'h0000_0100, 32,  1, 1, 0, 1, 1, 1, 0, 1, "R4");
    run_xfer(32'h0000_0203, 10,  1, 1, 0, 1, 2, 1, 1, 1, "R6");
    run_xfer(32'h0000_0400, 24,  0, 1, 1, 0, 1, 1, 0, 1, "R4");
    run_xfer(32'h0000_0500, 16,  0, 1, 0, 1, 3, 1, 0, 1, "R1");
    run_xfer(32'h0000_0600, 16,  1, 1, 1, 1, 0, 1, 0, 1, "R1");
    run_xfer(32'h0000_0700, 16,  1, 1, 1, 1, 2, 0, 1, 1, "R2");
    run_xfer(32'h0000_0800, 12,  1, 0, 1, 1, 2, 1, 0, 1, "R1");
    run_xfer(32'h0000_0900, 16,  0, 1, 1, 1, 2, 1, 0, 0, "R9");
    run_xfer(32'h0000_0031, 1,   1, 1, 1, 1, 1, 1, 0, 1, "R6");
    run_xfer(32'h0000_0A00, 120, 1, 1, 1, 1, 7, 1, 0, 1, "R4");
    run_xfer(32'h0000_0B02, 7,   0, 1, 1, 1, 1, 1, 1, 1, "R6");

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule